// File: doc/BRIEF.md
# Performance Counter Overflow Alert Unit

This block keeps six 32-bit event counters and a 64-bit mode control register. Each counter advances on a selected event: processor cycles, or completed instructions. When a counter that takes part in cycle-count alerting crosses into its negative range (top bit set) and its detection enable is on, the block sets a sticky alert flag. The flag is kept inside the control register. When the exception-enable bit is also set, the block pulses an event-based exception request.

Software loads any counter, or the control register, through single-cycle write strobes. The write data is stored as given. The detection state is checked again in the same cycle as every write. As a result, loading a counter that is already negative raises the alert on that same clock edge. Setting an enable while a counter is already negative also raises the alert on that edge.

Counter roles:
- Counters 1 to 4 count according to their own event-select field.
- Counter 5 always counts completed instructions and never raises an alert.
- Counter 6 always counts cycles and takes part in alerting.

Top module: `pmu_alert_unit`

## Requirements
- R1: A synchronous active-low reset clears all counters, the control register, the alert flag and the exception request.
- R2: Counters 1 to 4 add one per `cyc_tick` when their select is 0x1E, and add one per `inst_done` when their select is 0x02. Any other select leaves them unchanged. Counter 5 adds one per `inst_done`. Counter 6 adds one per `cyc_tick`.
- R3: Three control bits freeze counting, and each takes effect from the cycle after the write that sets it. Bit 31 (LSB-0) freezes all counters. Bit 5 freezes counters 1 to 4. Bit 4 freezes counters 5 and 6.
- R4: A counter write in the same cycle as an increment stores the written value, and the increment is lost.
- R5: A counter at 0xFFFFFFFF wraps to zero on an increment, and the wrap raises no alert.
- R6: The alert flag (control bit 7) sets on the clock edge where a counter's top bit becomes 1 by counting, if all of the following hold:
  - the counter takes part in alerting;
  - its detection is enabled: bit 15 for counter 1, bit 14 for counters 2 to 6.
- R7: Writing a value of 0x80000000 or more into a counter whose detection is enabled and that takes part in alerting sets the alert on the edge of that write.
- R8: A control write that turns on detection for a counter that is already negative sets the alert on the edge of that write.
- R9: Counter 5 never raises the alert. Counters 1 to 4 raise it only while their select is 0x1E.
- R10: The alert flag stays set until a control write with bit 7 clear. A new crossing in the same cycle as that clearing write keeps it set.
- R11: `exc_req` is a one-cycle pulse. It fires on the edge where the product of the alert flag and exception enable (bit 20) goes from 0 to 1.
- R12: A counter that stays negative after the alert is cleared does not set the alert again. Only a fresh crossing does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | One processor cycle elapsed |
| inst_done | input | 1 | One instruction completed |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 64 | Control register write data |
| cnt_we | input | 6 | Per-counter write strobes, bit 0 = counter 1 |
| cnt_wdata | input | 32 | Counter write data, shared |
| evsel | input | 48 | Event select, 8 bits per counter, counter 1 in bits 7:0 |
| cnt_value | output | 192 | Counter values, counter 1 in bits 31:0 |
| ctl_value | output | 64 | Control register contents |
| alert | output | 1 | Sticky monitor alert (control bit 7) |
| exc_req | output | 1 | Event-based exception request pulse |

## Verification
The bench builds the block with its default parameters: six counters of 32 bits and 8-bit selects. Counters are preloaded through the write port, which places 0x7FFFFFFE, 0x80000000 and 0xFFFFFFFF a few cycles away. The crossing, the immediate alert on load and the wrap can therefore all be reached quickly. A behavioural model runs alongside and is compared with every output on each clock. Directed checks with hand-computed values cover freezing, write priority, enable changes and exception pulses.

// File: rtl/pmu_alert_pkg.sv
// Package: shared control-register bit positions and counter role type.
// Assumes LSB-0 numbering of the 64-bit control register.
package pmu_alert_pkg;
    localparam int CTL_W      = 64;
    localparam int B_FRZ_ALL  = 31;   // freeze every counter
    localparam int B_EXC_EN   = 20;   // alert may request an exception
    localparam int B_EN_FIRST = 15;   // detection enable, counter 1
    localparam int B_EN_REST  = 14;   // detection enable, counters 2..N
    localparam int B_ALERT    = 7;    // sticky alert flag
    localparam int B_FRZ_LO   = 5;    // freeze selectable counters
    localparam int B_FRZ_HI   = 4;    // freeze the two fixed counters

    typedef enum logic [1:0] {
        ROLE_SELECT = 2'd0,
        ROLE_INSTR  = 2'd1,
        ROLE_CYCLE  = 2'd2
    } cnt_role_e;
endpackage

// File: rtl/pmu_event_sel.sv
// Module: decides whether one counter advances this cycle, and whether
// it takes part in cycle-count alerting.
// Assumes the event pulses are single-cycle and already synchronous.
module pmu_event_sel #(
    parameter int                      EVS_W     = 8,
    parameter logic [EVS_W-1:0]        CYC_CODE  = 8'h1E,
    parameter logic [EVS_W-1:0]        INST_CODE = 8'h02,
    parameter pmu_alert_pkg::cnt_role_e ROLE     = pmu_alert_pkg::ROLE_SELECT
) (
    input  logic [EVS_W-1:0] evsel,
    input  logic             cyc_tick,
    input  logic             inst_done,
    input  logic             frozen,
    output logic             inc,
    output logic             cyc_mode
);
    logic sel_cyc;
    logic sel_inst;

    // Purpose: decode the select field and apply the counter's fixed role.
    always_comb begin
        sel_cyc  = (evsel == CYC_CODE);
        sel_inst = (evsel == INST_CODE);
        case (ROLE)
            pmu_alert_pkg::ROLE_CYCLE: begin
                inc      = cyc_tick & ~frozen;
                cyc_mode = 1'b1;
            end
            pmu_alert_pkg::ROLE_INSTR: begin
                inc      = inst_done & ~frozen;
                cyc_mode = 1'b0;
            end
            default: begin
                inc      = ~frozen & ((sel_cyc & cyc_tick) | (sel_inst & inst_done));
                cyc_mode = sel_cyc;
            end
        endcase
    end
endmodule

// File: rtl/pmu_counter.sv
// Module: one event counter with a write port and wrap-around increment.
// It exports its next value so that the negative state can be judged in
// the same cycle as a write. Assumes a write outranks an increment.
module pmu_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             inc,
    output logic [CNT_W-1:0] value,
    output logic             neg_next
);
    logic [CNT_W-1:0] nxt;

    // Purpose: choose between the written value, the increment and holding.
    always_comb begin
        if (we)       nxt = wdata;
        else if (inc) nxt = value + 1'b1;
        else          nxt = value;
    end

    assign neg_next = nxt[CNT_W-1];

    // Purpose: counter storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= '0;
        else        value <= nxt;
    end

    // R4: a write always lands
    p_write_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (value == $past(wdata)));
    // R5: all-ones wraps to zero
    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && inc && (value == {CNT_W{1'b1}})) |=> (value == '0));
    // R2: no event, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !inc) |=> $stable(value));
    // R2: an event below all-ones adds exactly one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && inc && (value != {CNT_W{1'b1}})) |=> (value == CNT_W'($past(value) + 1'b1)));
endmodule

// File: rtl/pmu_alert_ctl.sv
// Module: control register, per-counter negative qualification, sticky
// alert and exception pulse. Assumes the neg_next inputs describe the
// counter values as they will stand after this edge.
module pmu_alert_ctl #(
    parameter int NUM_CNT = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ctl_we,
    input  logic [pmu_alert_pkg::CTL_W-1:0] ctl_wdata,
    input  logic [NUM_CNT-1:0]              neg_next,
    input  logic [NUM_CNT-1:0]              part,
    output logic [pmu_alert_pkg::CTL_W-1:0] ctl_q,
    output logic                            alert,
    output logic                            exc_req
);
    import pmu_alert_pkg::*;

    logic [CTL_W-1:0]   ctl_next;
    logic [CTL_W-1:0]   ctl_d;
    logic [NUM_CNT-1:0] qual_next;
    logic [NUM_CNT-1:0] qual_q;
    logic               rise;
    logic               exc_d;

    assign ctl_next = ctl_we ? ctl_wdata : ctl_q;

    // Purpose: qualify each counter against the enable it will have after this edge.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_qual
        if (i == 0) begin : g_first
            assign qual_next[i] = ctl_next[B_EN_FIRST] & part[i] & neg_next[i];
        end else begin : g_rest
            assign qual_next[i] = ctl_next[B_EN_REST] & part[i] & neg_next[i];
        end
    end

    assign rise = |(qual_next & ~qual_q);

    // Purpose: merge a fresh crossing into the alert bit and form the pulse.
    always_comb begin
        ctl_d          = ctl_next;
        ctl_d[B_ALERT] = ctl_next[B_ALERT] | rise;
        exc_d          = ctl_d[B_ALERT] & ctl_d[B_EXC_EN] & ~(ctl_q[B_ALERT] & ctl_q[B_EXC_EN]);
    end

    // Purpose: control, qualification history and exception pulse storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            qual_q  <= '0;
            exc_req <= 1'b0;
        end else begin
            ctl_q   <= ctl_d;
            qual_q  <= qual_next;
            exc_req <= exc_d;
        end
    end

    assign alert = ctl_q[B_ALERT];

    // R11: the request never lasts two cycles
    p_exc_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !exc_req);
    // R11: the request needs both the alert and the exception enable
    p_exc_qual_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (alert && ctl_q[B_EXC_EN]));
    // R10: only a control write clears the alert
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alert && !ctl_we) |=> alert);
endmodule

// File: rtl/pmu_alert_unit.sv
// Module: top of the counter overflow alert unit. Builds the counters and
// their event selectors, then feeds their next-state negative bits to the
// alert controller. Assumes NUM_CNT >= 3:
//   - the last counter counts cycles;
//   - the one before it counts instructions;
//   - the rest use their select field.
module pmu_alert_unit #(
    parameter int              NUM_CNT   = 6,
    parameter int              CNT_W     = 32,
    parameter int              EVS_W     = 8,
    parameter logic [EVS_W-1:0] CYC_CODE  = 8'h1E,
    parameter logic [EVS_W-1:0] INST_CODE = 8'h02
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cyc_tick,
    input  logic                     inst_done,
    input  logic                     ctl_we,
    input  logic [63:0]              ctl_wdata,
    input  logic [NUM_CNT-1:0]       cnt_we,
    input  logic [CNT_W-1:0]         cnt_wdata,
    input  logic [NUM_CNT*EVS_W-1:0] evsel,
    output logic [NUM_CNT*CNT_W-1:0] cnt_value,
    output logic [63:0]              ctl_value,
    output logic                     alert,
    output logic                     exc_req
);
    import pmu_alert_pkg::*;

    localparam int N_SELECT = NUM_CNT - 2;

    logic [CTL_W-1:0]   ctl_q;
    logic [NUM_CNT-1:0] neg_next;
    logic [NUM_CNT-1:0] part;
    logic [NUM_CNT-1:0] inc;
    logic [NUM_CNT-1:0] frozen;

    // Purpose: one selector and one counter per slot, role chosen by position.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam cnt_role_e ROLE = (i == NUM_CNT - 1) ? ROLE_CYCLE :
                                     (i == NUM_CNT - 2) ? ROLE_INSTR : ROLE_SELECT;

        assign frozen[i] = ctl_q[B_FRZ_ALL] |
                           ((i < N_SELECT) ? ctl_q[B_FRZ_LO] : ctl_q[B_FRZ_HI]);

        pmu_event_sel #(
            .EVS_W(EVS_W), .CYC_CODE(CYC_CODE), .INST_CODE(INST_CODE), .ROLE(ROLE)
        ) u_sel (
            .evsel    (evsel[i*EVS_W +: EVS_W]),
            .cyc_tick (cyc_tick),
            .inst_done(inst_done),
            .frozen   (frozen[i]),
            .inc      (inc[i]),
            .cyc_mode (part[i])
        );

        pmu_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (cnt_we[i]),
            .wdata   (cnt_wdata),
            .inc     (inc[i]),
            .value   (cnt_value[i*CNT_W +: CNT_W]),
            .neg_next(neg_next[i])
        );
    end

    pmu_alert_ctl #(.NUM_CNT(NUM_CNT)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .ctl_wdata(ctl_wdata),
        .neg_next (neg_next),
        .part     (part),
        .ctl_q    (ctl_q),
        .alert    (alert),
        .exc_req  (exc_req)
    );

    assign ctl_value = ctl_q;

    // R9: the instruction-only counter never takes part in alerting
    p_instr_never_alerts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !part[NUM_CNT-2]);
endmodule

// File: tb/pmu_alert_unit_test.sv
module pmu_alert_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_tick = 1'b0, inst_done = 1'b0, ctl_we = 1'b0;
    logic [63:0] ctl_wdata = '0;
    logic [5:0]  cnt_we = '0;
    logic [31:0] cnt_wdata = '0;
    logic [47:0] evsel = '0;
    logic [191:0] cnt_value;
    logic [63:0] ctl_value;
    logic        alert, exc_req;

    int checks = 0, failures = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    pmu_alert_unit uut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .inst_done(inst_done),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .evsel(evsel), .cnt_value(cnt_value), .ctl_value(ctl_value),
        .alert(alert), .exc_req(exc_req));

    // Behavioural reference state
    logic [31:0] m_cnt [6];
    logic [63:0] m_ctl;
    bit   [5:0]  m_q;
    bit          m_exc;

    always @(posedge clk) begin : model
        logic [63:0] nc;
        logic [31:0] nv;
        bit rise, frz, counts, takes, en, qn, prev;
        logic [7:0] ev;
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_cnt[i] = '0;
            m_ctl = '0; m_q = '0; m_exc = 1'b0;
        end else begin
            nc = ctl_we ? ctl_wdata : m_ctl;
            rise = 1'b0;
            for (int i = 0; i < 6; i++) begin
                ev = evsel[i*8 +: 8];
                frz = m_ctl[31] || (i < 4 ? m_ctl[5] : m_ctl[4]);
                if (i == 5)      counts = cyc_tick;
                else if (i == 4) counts = inst_done;
                else counts = (ev == 8'h1E && cyc_tick) || (ev == 8'h02 && inst_done);
                takes = (i == 5) || (i < 4 && ev == 8'h1E);
                if (cnt_we[i])          nv = cnt_wdata;
                else if (counts && !frz) nv = m_cnt[i] + 32'd1;
                else                    nv = m_cnt[i];
                en = (i == 0) ? nc[15] : nc[14];
                qn = takes && en && nv[31];
                if (qn && !m_q[i]) rise = 1'b1;
                m_q[i] = qn;
                m_cnt[i] = nv;
            end
            if (rise) nc[7] = 1'b1;
            prev = m_ctl[7] && m_ctl[20];
            m_exc = nc[7] && nc[20] && !prev;
            m_ctl = nc;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            for (int i = 0; i < 6; i++) chk("R2 model counter", cnt_value[i*32 +: 32], m_cnt[i]);
            chk("R3 model control", ctl_value, m_ctl);
            chk("R10 model alert", alert, m_ctl[7]);
            chk("R11 model exc_req", exc_req, m_exc);
        end
    end

    function automatic logic [31:0] cv(input int i);
        return cnt_value[i*32 +: 32];
    endfunction

    task automatic wr_ctl(input logic [63:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_cnt(input int i, input logic [31:0] v);
        cnt_we = 6'(1 << i); cnt_wdata = v;
        @(negedge clk);
        cnt_we = '0;
    endtask

    task automatic pulses(input int n, input bit c, input bit ins);
        for (int k = 0; k < n; k++) begin
            cyc_tick = c; inst_done = ins;
            @(negedge clk);
        end
        cyc_tick = 1'b0; inst_done = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 6; i++) chk("R1 counter at reset", cv(i), 32'd0);
        chk("R1 control at reset", ctl_value, 64'd0);
        chk("R1 alert at reset", alert, 1'b0);
        chk("R1 exc_req at reset", exc_req, 1'b0);
        rst_n = 1'b1; model_on = 1'b1;
        evsel = {8'h00, 8'h00, 8'h00, 8'h05, 8'h02, 8'h1E};
        @(negedge clk);

        // R2: event selection
        pulses(3, 1'b1, 1'b0);
        pulses(2, 1'b0, 1'b1);
        chk("R2 counter1 cycles", cv(0), 32'd3);
        chk("R2 counter2 instructions", cv(1), 32'd2);
        chk("R2 counter3 other code", cv(2), 32'd0);
        chk("R2 counter4 code zero", cv(3), 32'd0);
        chk("R2 counter5 instructions", cv(4), 32'd2);
        chk("R2 counter6 cycles", cv(5), 32'd3);

        // R3: freeze groups
        wr_ctl(64'h20);
        pulses(2, 1'b1, 1'b0);
        chk("R3 low group frozen", cv(0), 32'd3);
        chk("R3 counter6 runs", cv(5), 32'd5);
        wr_ctl(64'h10);
        pulses(2, 1'b1, 1'b0);
        chk("R3 low group runs", cv(0), 32'd5);
        chk("R3 high group frozen", cv(5), 32'd5);
        wr_ctl(64'h8000_0000);
        pulses(2, 1'b1, 1'b1);
        chk("R3 all frozen c1", cv(0), 32'd5);
        chk("R3 all frozen c2", cv(1), 32'd2);
        chk("R3 all frozen c5", cv(4), 32'd2);
        wr_ctl(64'h0);

        // R4: write beats increment
        cyc_tick = 1'b1;
        wr_cnt(0, 32'd100);
        cyc_tick = 1'b0;
        chk("R4 write wins", cv(0), 32'd100);

        // R7 and R5: load negative value, clear, then wrap
        wr_ctl(64'h8000);
        wr_cnt(0, 32'hFFFF_FFFF);
        chk("R7 alert on negative load", alert, 1'b1);
        wr_ctl(64'h8000);
        chk("R10 alert cleared by write", alert, 1'b0);
        repeat (2) @(negedge clk);
        chk("R12 no re-raise while held negative", alert, 1'b0);
        pulses(1, 1'b1, 1'b0);
        chk("R5 wrap to zero", cv(0), 32'd0);
        chk("R5 wrap raises nothing", alert, 1'b0);

        // R6: crossing by counting
        wr_cnt(0, 32'h7FFF_FFFE);
        pulses(1, 1'b1, 1'b0);
        chk("R6 below threshold", alert, 1'b0);
        pulses(1, 1'b1, 1'b0);
        chk("R6 counter at threshold", cv(0), 32'h8000_0000);
        chk("R6 alert on crossing", alert, 1'b1);
        wr_ctl(64'h8000);

        // R8: enable while already negative
        evsel[15:8] = 8'h1E;
        wr_cnt(1, 32'h9000_0000);
        chk("R8 shared enable off", alert, 1'b0);
        wr_ctl(64'hC000);
        chk("R8 alert on enable write", alert, 1'b1);
        wr_ctl(64'hC000);
        chk("R10 cleared again", alert, 1'b0);

        // R9: non-participating counters
        wr_cnt(4, 32'h8000_0000);
        wr_cnt(2, 32'h8000_0000);
        chk("R9 counter5 and counter3 silent", alert, 1'b0);
        wr_cnt(5, 32'h8000_0000);
        chk("R7 counter6 load alerts", alert, 1'b1);

        // R11: exception pulse
        chk("R11 no request without enable", exc_req, 1'b0);
        wr_ctl(64'h10_C080);
        chk("R11 request on enable", exc_req, 1'b1);
        @(negedge clk);
        chk("R11 request is one cycle", exc_req, 1'b0);
        wr_ctl(64'h10_C000);
        chk("R10 clear with exception enabled", alert, 1'b0);
        wr_cnt(0, 32'd0);
        wr_cnt(0, 32'h8000_0000);
        chk("R11 alert with request", alert, 1'b1);
        chk("R11 request with new alert", exc_req, 1'b1);

        // R10: crossing in the clearing cycle keeps the flag
        wr_cnt(0, 32'd0);
        ctl_we = 1'b1; ctl_wdata = 64'h10_C000;
        cnt_we = 6'b000001; cnt_wdata = 32'h8000_0000;
        @(negedge clk);
        ctl_we = 1'b0; cnt_we = '0;
        chk("R10 set wins over clear", alert, 1'b1);
        chk("R11 no request while already high", exc_req, 1'b0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule